// File: doc/BRIEF.md
# Low-Power Real-Time Counter with Alarm

This block is a real-time counter peripheral. Software reaches it through a 32-bit register interface on the fast bus clock. The counting logic runs in a slow domain that ticks at 32.768 kHz. The slow domain is modelled here as a single-cycle enable pulse, produced by dividing the bus clock. The counter is 47 bits wide. Its upper 32 bits hold whole seconds and its lower 15 bits hold a fraction of a second. Software reads the counter through two registers, one for the high part and one for the low part. There is no snapshot latch, so two reads taken a few cycles apart can return a torn value.

A seconds-resolution alarm compares the counter's seconds field with an alarm register. When the two become equal, a sticky status flag sets. The flag drives an interrupt output while the alarm is enabled. It also drives a wakeup output while the wakeup enable is set as well.

Every control value crosses into the slow domain through two-flop synchronizers. Multi-bit values (a counter load, an alarm value) cross through a request/acknowledge handshake. The enable state that is actually in effect comes back to the bus side through synchronizers. A plain 32-bit glitch-detect register sits alongside, for software to program at start-up.

Top module: `rtc_lp_top`

## Requirements
- R1: While counting is in effect, the counter grows by exactly one on every slow tick, and the tick recurs every DIV bus cycles. Register 0x1C reads the counter bits 46:32 in its bits 14:0, with zeros above them. Register 0x20 reads the counter bits 31:0. The seconds value is the counter bits 46:15.
- R2: A write to 0x20 only stages the low 32 bits. A write to 0x1C commits the staged low part, together with the written bits 14:0, as a 47-bit load into the slow domain. The load takes effect only while counting is not in effect, and is discarded otherwise. While disabled, the counter holds its value.
- R3: The control register (0x04) has three defined bits: bit 0 is the count enable, bit 1 the alarm enable and bit 3 the wakeup enable. Bits 1 and 3 read back as written. Bit 0 reads back the enable state in effect in the slow domain, so right after a write it still shows the old state. All other bits read as zero.
- R4: Status bit 0 (0x18) sets when the seconds field becomes equal to the alarm register. It stays set until it is cleared, even after the enables change.
- R5: Writing 1 to status bit 0 clears the flag. Writing 0 leaves it unchanged.
- R6: irq_o is the flag ANDed with the alarm enable in effect. wake_o is irq_o further ANDed with the wakeup enable in effect.
- R7: The alarm register (0x24) is read/write and resets to all ones. Its value is carried into the slow domain for the comparison.
- R8: The glitch-detect register (0x30) is a 32-bit read/write register and resets to zero.
- R9: After reset, control, status and counter read zero, and irq_o and wake_o are low.
- R10: Offsets that are not mapped read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational on bus_addr |
| irq_o | output | 1 | Alarm interrupt |
| wake_o | output | 1 | Wakeup request |

## Verification
The assertions check four behaviours on every cycle:
- the counter advances by one on each enabled tick and otherwise stays still unless a load lands;
- the flag stays set unless a write of 1 to the status register clears it;
- irq_o never rises without the flag, and wake_o never rises without irq_o;
- the enable in effect changes only on a slow tick.

The bench scenarios show what a single-cycle property cannot capture:
- the lag between a control write and its readback;
- staging and commit of a counter load, and its rejection while counting;
- an alarm match reached across a seconds boundary;
- the irq/wake gating as the enables change, and the write-one-to-clear behaviour.

// File: rtl/rtc_lp_pkg.sv
package rtc_lp_pkg;

    localparam int CNT_W  = 47;
    localparam int FRAC_W = 15;
    localparam int SEC_W  = CNT_W - FRAC_W;
    localparam int LO_W   = 32;
    localparam int HI_W   = CNT_W - LO_W;

    localparam logic [7:0] OFS_CTRL  = 8'h04;
    localparam logic [7:0] OFS_STAT  = 8'h18;
    localparam logic [7:0] OFS_CHI   = 8'h1C;
    localparam logic [7:0] OFS_CLO   = 8'h20;
    localparam logic [7:0] OFS_ALARM = 8'h24;
    localparam logic [7:0] OFS_GLTCH = 8'h30;

    typedef struct packed {
        logic wake_en;
        logic alarm_en;
        logic run;
    } ctrl_t;

    typedef enum logic [2:0] {
        SEL_NONE, SEL_CTRL, SEL_STAT, SEL_CHI, SEL_CLO, SEL_ALARM, SEL_GLTCH
    } reg_sel_e;

    function automatic reg_sel_e decode_ofs(input logic [7:0] ofs);
        case (ofs)
            OFS_CTRL:  return SEL_CTRL;
            OFS_STAT:  return SEL_STAT;
            OFS_CHI:   return SEL_CHI;
            OFS_CLO:   return SEL_CLO;
            OFS_ALARM: return SEL_ALARM;
            OFS_GLTCH: return SEL_GLTCH;
            default:   return SEL_NONE;
        endcase
    endfunction

    function automatic logic [31:0] pack_ctrl(input ctrl_t c, input logic run_rb);
        logic [31:0] v;
        v = '0;
        v[0] = run_rb;
        v[1] = c.alarm_en;
        v[3] = c.wake_en;
        return v;
    endfunction

endpackage

// File: rtl/rtc_sync2.sv
module rtc_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s1_q, s2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= '0;
            s2_q <= '0;
        end else if (en) begin
            s1_q <= d;
            s2_q <= s1_q;
        end
    end

    assign q = s2_q;
endmodule

// File: rtl/rtc_tick_gen.sv
module rtc_tick_gen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [DW-1:0] LAST = DW'(DIV - 1);

    logic [DW-1:0] div_q;

    always_ff @(posedge clk) begin
        if (rst)                div_q <= '0;
        else if (div_q == LAST) div_q <= '0;
        else                    div_q <= div_q + 1'b1;
    end

    assign tick = (div_q == LAST);
endmodule

// File: rtl/rtc_xfer.sv
module rtc_xfer #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         wr,
    input  logic [W-1:0] wr_data,
    output logic         busy,
    output logic         slow_valid,
    output logic [W-1:0] slow_data
);
    logic         req_q;
    logic [W-1:0] hold_q;
    logic         req_s, ack_s_q, ack_b;

    // bus side: hold word stable until the acknowledge round trip ends
    always_ff @(posedge clk) begin
        if (rst) begin
            req_q  <= 1'b0;
            hold_q <= '0;
        end else if (wr && !busy) begin
            req_q  <= 1'b1;
            hold_q <= wr_data;
        end else if (ack_b) begin
            req_q  <= 1'b0;
        end
    end

    assign busy = req_q | ack_b;

    rtc_sync2 #(.W(1)) i_req_sync (
        .clk(clk), .rst(rst), .en(tick), .d(req_q), .q(req_s)
    );

    always_ff @(posedge clk) begin
        if (rst)       ack_s_q <= 1'b0;
        else if (tick) ack_s_q <= req_s;
    end

    rtc_sync2 #(.W(1)) i_ack_sync (
        .clk(clk), .rst(rst), .en(1'b1), .d(ack_s_q), .q(ack_b)
    );

    assign slow_valid = tick & req_s & ~ack_s_q;
    assign slow_data  = hold_q;
endmodule

// File: rtl/rtc_counter.sv
module rtc_counter
    import rtc_lp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             run,
    input  logic             ld,
    input  logic [CNT_W-1:0] ld_data,
    output logic [CNT_W-1:0] cnt
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)               cnt_q <= '0;
        else if (tick && run)  cnt_q <= cnt_q + 1'b1;
        else if (tick && ld)   cnt_q <= ld_data;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
    import rtc_lp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [SEC_W-1:0] sec,
    input  logic             alm_ld,
    input  logic [SEC_W-1:0] alm_data,
    input  logic             clr,
    output logic             flag
);
    logic [SEC_W-1:0] alarm_s_q;
    logic             match_s_q, match_b, match_b_q, flag_q;

    // slow domain: alarm copy and compare
    always_ff @(posedge clk) begin
        if (rst) begin
            alarm_s_q <= '1;
            match_s_q <= 1'b0;
        end else if (tick) begin
            if (alm_ld) alarm_s_q <= alm_data;
            match_s_q <= (sec == alarm_s_q);
        end
    end

    rtc_sync2 #(.W(1)) i_match_sync (
        .clk(clk), .rst(rst), .en(1'b1), .d(match_s_q), .q(match_b)
    );

    // bus domain: sticky flag set on the match edge, set wins over clear
    always_ff @(posedge clk) begin
        if (rst) begin
            match_b_q <= 1'b0;
            flag_q    <= 1'b0;
        end else begin
            match_b_q <= match_b;
            if (match_b && !match_b_q) flag_q <= 1'b1;
            else if (clr)              flag_q <= 1'b0;
        end
    end

    assign flag = flag_q;
endmodule

// File: rtl/rtc_lp_top.sv
module rtc_lp_top
    import rtc_lp_pkg::*;
#(
    parameter int DIV = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_we,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq_o,
    output logic        wake_o
);
    reg_sel_e         sel;
    ctrl_t            ctrl_q, ctrl_s, ctrl_b;
    logic             tick;
    logic [LO_W-1:0]  stage_lo_q;
    logic [31:0]      alarm_sh_q, gltch_q;
    logic             ld_busy, ld_valid, alm_busy, alm_valid;
    logic [CNT_W-1:0] ld_data, cnt;
    logic [SEC_W-1:0] alm_data;
    logic             flag, clr_hit;

    assign sel     = decode_ofs(bus_addr);
    assign clr_hit = bus_we && (sel == SEL_STAT) && bus_wdata[0];

    rtc_tick_gen #(.DIV(DIV)) i_tick (.clk(clk), .rst(rst), .tick(tick));

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q     <= '0;
            stage_lo_q <= '0;
            alarm_sh_q <= '1;
            gltch_q    <= '0;
        end else if (bus_we) begin
            case (sel)
                SEL_CTRL: begin
                    ctrl_q.run      <= bus_wdata[0];
                    ctrl_q.alarm_en <= bus_wdata[1];
                    ctrl_q.wake_en  <= bus_wdata[3];
                end
                SEL_CLO:   stage_lo_q <= bus_wdata;
                SEL_ALARM: if (!alm_busy) alarm_sh_q <= bus_wdata;
                SEL_GLTCH: gltch_q <= bus_wdata;
                default: ;
            endcase
        end
    end

    rtc_sync2 #(.W($bits(ctrl_t))) i_ctrl_to_slow (
        .clk(clk), .rst(rst), .en(tick), .d(ctrl_q), .q(ctrl_s)
    );
    rtc_sync2 #(.W($bits(ctrl_t))) i_ctrl_to_bus (
        .clk(clk), .rst(rst), .en(1'b1), .d(ctrl_s), .q(ctrl_b)
    );

    rtc_xfer #(.W(CNT_W)) i_ld_xfer (
        .clk(clk), .rst(rst), .tick(tick),
        .wr(bus_we && (sel == SEL_CHI)),
        .wr_data({bus_wdata[HI_W-1:0], stage_lo_q}),
        .busy(ld_busy), .slow_valid(ld_valid), .slow_data(ld_data)
    );

    rtc_xfer #(.W(SEC_W)) i_alm_xfer (
        .clk(clk), .rst(rst), .tick(tick),
        .wr(bus_we && (sel == SEL_ALARM)),
        .wr_data(bus_wdata),
        .busy(alm_busy), .slow_valid(alm_valid), .slow_data(alm_data)
    );

    rtc_counter i_cnt (
        .clk(clk), .rst(rst), .tick(tick), .run(ctrl_s.run),
        .ld(ld_valid), .ld_data(ld_data), .cnt(cnt)
    );

    rtc_alarm i_alm (
        .clk(clk), .rst(rst), .tick(tick), .sec(cnt[CNT_W-1:FRAC_W]),
        .alm_ld(alm_valid), .alm_data(alm_data), .clr(clr_hit), .flag(flag)
    );

    assign irq_o  = flag & ctrl_b.alarm_en;
    assign wake_o = irq_o & ctrl_b.wake_en;

    always_comb begin
        case (sel)
            SEL_CTRL:  bus_rdata = pack_ctrl(ctrl_q, ctrl_b.run);
            SEL_STAT:  bus_rdata = {31'b0, flag};
            SEL_CHI:   bus_rdata = {{(32-HI_W){1'b0}}, cnt[CNT_W-1:LO_W]};
            SEL_CLO:   bus_rdata = cnt[LO_W-1:0];
            SEL_ALARM: bus_rdata = alarm_sh_q;
            SEL_GLTCH: bus_rdata = gltch_q;
            default:   bus_rdata = '0;
        endcase
    end

    logic unused_busy;
    assign unused_busy = ld_busy;
endmodule

// File: rtl/rtc_lp_chk.sv
module rtc_lp_chk
    import rtc_lp_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic             run_s,
    input logic             ld_valid,
    input logic [CNT_W-1:0] cnt,
    input logic             flag,
    input logic             clr_hit,
    input logic             irq_o,
    input logic             wake_o
);
    // R1
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && run_s) |=> (cnt == $past(cnt) + 1'b1));

    // R2
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(tick && (run_s || ld_valid)) |=> $stable(cnt));

    // R5
    flag_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr_hit) |=> flag);

    // R6
    irq_flag_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> flag);

    // R6
    wake_irq_chk: assert property (@(posedge clk) disable iff (rst)
        wake_o |-> irq_o);

    // R3
    run_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (run_s != $past(run_s)) |-> $past(tick));
endmodule

bind rtc_lp_top rtc_lp_chk i_rtc_lp_chk (
    .clk(clk), .rst(rst), .tick(tick), .run_s(ctrl_s.run),
    .ld_valid(ld_valid), .cnt(cnt), .flag(flag), .clr_hit(clr_hit),
    .irq_o(irq_o), .wake_o(wake_o)
);

// File: tb/test_rtc_lp_top.sv
`timescale 1ns/1ps
module test_rtc_lp_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        bus_we;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        irq_o, wake_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    rtc_lp_top #(.DIV(4)) i_rtc_lp_top (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .wake_o(wake_o)
    );

    // {we, addr, wdata/expected, requirement number}
    localparam int NV = 13;
    localparam logic [44:0] VEC [NV] = '{
        {1'b1, 8'h30, 32'h41736166, 4'd8},  // R8 program glitch register
        {1'b0, 8'h30, 32'h41736166, 4'd8},
        {1'b1, 8'h24, 32'h00000055, 4'd7},  // R7 alarm read/write
        {1'b0, 8'h24, 32'h00000055, 4'd7},
        {1'b1, 8'h04, 32'h0000000A, 4'd3},  // R3 alarm + wake enables
        {1'b0, 8'h04, 32'h0000000A, 4'd3},
        {1'b1, 8'h04, 32'hFFFFFFF4, 4'd3},  // undefined bits read zero
        {1'b0, 8'h04, 32'h00000000, 4'd3},
        {1'b1, 8'h18, 32'h00000000, 4'd5},  // R5 write 0 harmless
        {1'b0, 8'h18, 32'h00000000, 4'd5},
        {1'b0, 8'h08, 32'h00000000, 4'd10}, // R10 unmapped
        {1'b0, 8'h3C, 32'h00000000, 4'd10},
        {1'b0, 8'h2C, 32'h00000000, 4'd10}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [31:0] v, a, b;
        rst = 1'b1; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        idle(5);
        rst = 1'b0;
        idle(1);

        // R9 reset state
        rd(8'h04, v); check("R9 ctrl", v, 32'h0);
        rd(8'h18, v); check("R9 status", v, 32'h0);
        rd(8'h1C, v); check("R9 cnt hi", v, 32'h0);
        rd(8'h20, v); check("R9 cnt lo", v, 32'h0);
        rd(8'h24, v); check("R7 alarm reset", v, 32'hFFFFFFFF);
        rd(8'h30, v); check("R8 glitch reset", v, 32'h0);
        check("R9 irq", {31'b0, irq_o}, 32'h0);
        check("R9 wake", {31'b0, wake_o}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][44]) begin
                wr(VEC[i][43:36], VEC[i][35:4]);
                idle(40);
            end else begin
                rd(VEC[i][43:36], v);
                check($sformatf("R%0d table %0d", VEC[i][3:0], i), v, VEC[i][35:4]);
            end
        end

        // R3 enable readback lags the write
        wr(8'h04, 32'h1);
        rd(8'h04, v); check("R3 run not yet in effect", v, 32'h0);
        idle(40);
        rd(8'h04, v); check("R3 run in effect", v, 32'h1);

        // R1 one step per tick, tick every 4 bus cycles
        rd(8'h20, a);
        idle(40);
        rd(8'h20, b);
        check("R1 count rate", b - a, 32'd10);

        // R2 hold while disabled
        wr(8'h04, 32'h0);
        idle(40);
        rd(8'h20, a);
        idle(40);
        rd(8'h20, b);
        check("R2 hold", b, a);

        // R2 staged load commits on high write
        wr(8'h20, 32'h0001FFF0);
        wr(8'h1C, 32'h1);
        idle(60);
        rd(8'h1C, v); check("R2 load hi", v, 32'h1);
        rd(8'h20, v); check("R2 load lo", v, 32'h0001FFF0);

        // R2 load discarded while counting
        wr(8'h04, 32'h1);
        idle(40);
        wr(8'h20, 32'h0);
        wr(8'h1C, 32'h7);
        idle(60);
        rd(8'h1C, v); check("R2 load ignored while running", v, 32'h1);

        // alarm scenario: seconds 0x20003 with fraction 0x7FF0, alarm 0x20004
        wr(8'h04, 32'h0);
        idle(40);
        wr(8'h20, 32'h0001FFF0);
        wr(8'h1C, 32'h1);
        idle(60);
        wr(8'h24, 32'h00020004);
        idle(60);
        rd(8'h18, v); check("R4 no early flag", v, 32'h0);
        wr(8'h04, 32'hB);
        idle(300);
        rd(8'h18, v); check("R4 flag set at match", v, 32'h1);
        check("R6 irq", {31'b0, irq_o}, 32'h1);
        check("R6 wake", {31'b0, wake_o}, 32'h1);

        wr(8'h04, 32'h3);
        idle(40);
        check("R6 irq kept", {31'b0, irq_o}, 32'h1);
        check("R6 wake gated", {31'b0, wake_o}, 32'h0);

        wr(8'h04, 32'h1);
        idle(40);
        check("R6 irq gated", {31'b0, irq_o}, 32'h0);
        rd(8'h18, v); check("R4 flag sticky", v, 32'h1);

        // R5 write-one-to-clear
        wr(8'h18, 32'h0);
        rd(8'h18, v); check("R5 write 0 keeps flag", v, 32'h1);
        wr(8'h18, 32'h1);
        rd(8'h18, v); check("R5 write 1 clears", v, 32'h0);
        wr(8'h04, 32'h3);
        idle(40);
        check("R6 irq after clear", {31'b0, irq_o}, 32'h0);

        done = 1'b1;
        finish_run();
    end
endmodule